// File: doc/BRIEF.md
# UDP Register Access Processor

This block serves remote register reads and writes that a host sends inside UDP datagrams. Neighbouring blocks strip the Ethernet, IP and UDP headers from incoming requests and add them to outgoing responses. Requests and responses both use UDP port 1001. The processor receives only the payload, as a stream of 16-bit words. It decides whether the request is a read or a write, decodes the register address into a one-hot subsystem select, and performs a single access on a simple internal register bus. It then streams a fixed-length response payload back to the framing logic.

The processor handles one request at a time. After it accepts the last word of a request, it accepts no new words until the host-side consumer has taken the last word of the response.

Requests with an unknown type code or an unmapped address never reach the bus and are answered with an error status. An access whose acknowledge does not arrive in time is closed with a timeout status.

Top module: `reg_access_proc`

## Requirements
- R1: A request is five 16-bit words, each taken when `req_valid_i` and `req_ready_o` are both high, in this order: type code, address bits 31:16, address bits 15:0, data bits 31:16, data bits 15:0. Read requests also carry the data words.
- R2: Type code 0x2000 is a read. It gives one bus strobe with `bus_we_o` low, and the response data is the `bus_rdata_i` value presented with the acknowledge.
- R3: Type code 0x2001 is a write. It gives one bus strobe with `bus_we_o` high and `bus_wdata_o` equal to the request data, and the response data echoes the request data.
- R4: Any other type code produces no strobe, returns status 0x0001, and echoes the request data. This check takes precedence over the address check.
- R5: The address decode uses the top nibble, address bits 31:28:
  - 0x0 and 0x1 raise select bit 0 (processor core region).
  - 0x2 (framework region) selects by address bits 27:24: value 0x0, 0x1 or 0x2 raises select bit (value+1); values 0x4 through 0xD raise the select bit equal to the value.
  - Exactly one bit of the 14-bit `bus_sel_o` is high from the strobe until the access ends, and all bits are low at other times.
- R6: An unmapped address produces no strobe, returns status 0x0002, and returns read data of zero. Unmapped means a top nibble of 0x3 to 0xF, or a framework sub-field of 0x3, 0xE or 0xF.
- R7: The strobe lasts one cycle. Address, write flag, write data and select stay unchanged until the access ends.
- R8: An acknowledge in any of the 256 cycles after the strobe cycle completes the access with status 0x0000. Without one, the access ends with status 0x0003 and read data zero. A later acknowledge is ignored.
- R9: A response is six words: type code, status, address high, address low, data high, data low. `rsp_last_o` is high only on the sixth word. A word is held unchanged while `rsp_ready_i` is low.
- R10: `req_ready_o` is low whenever a response word is offered, and no strobe occurs while a response is being emitted.
- R11: `rsp_port_o` carries the UDP port number 1001 that the framing blocks use in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request word valid |
| req_ready_o | output | 1 | Request word accepted when high |
| req_data_i | input | 16 | Request payload word |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_data_o | output | 16 | Response payload word |
| rsp_last_o | output | 1 | Final response word |
| rsp_port_o | output | 16 | UDP port for request and response framing |
| bus_stb_o | output | 1 | One-cycle access strobe |
| bus_we_o | output | 1 | Write when high |
| bus_addr_o | output | 32 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_sel_o | output | 14 | One-hot subsystem select |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The hardest case to reach from the ports is the timeout boundary. The bench must show that an acknowledge in the 256th cycle after the strobe still counts as success, while one in the 257th cycle is too late and has to be ignored. The bench's bus responder counts cycles from the strobe it sees and answers at a programmed latency of 1, 256 or 257 cycles, or never. The same responder also drives every address nibble pair through the decoder, with read and write types plus foreign type codes.

// File: rtl/rap_pkg.sv
package rap_pkg;
  localparam int WORD_W = 16;
  localparam logic [15:0] TYPE_RD = 16'h2000;
  localparam logic [15:0] TYPE_WR = 16'h2001;
  localparam logic [15:0] STS_OK       = 16'h0000;
  localparam logic [15:0] STS_BAD_TYPE = 16'h0001;
  localparam logic [15:0] STS_BAD_ADDR = 16'h0002;
  localparam logic [15:0] STS_TIMEOUT  = 16'h0003;
  localparam int APP_SLOTS = 8;
  localparam int SEL_W = 6 + APP_SLOTS;

  typedef enum logic [1:0] {ST_RX, ST_CHK, ST_BUS, ST_TX} rap_state_e;
endpackage

// File: rtl/rap_req_parser.sv
module rap_req_parser #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [W-1:0]      data_i,
  output logic              done_o,
  output logic [W-1:0]      type_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int NWORDS = 1 + ADDR_W / W + DATA_W / W;
  localparam int CNT_W  = $clog2(NWORDS);

  logic [NWORDS*W-1:0] sreg_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                take;

  assign take   = en_i && valid_i;
  assign done_o = take && (cnt_q == CNT_W'(NWORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      sreg_q <= {sreg_q[(NWORDS-1)*W-1:0], data_i};
      cnt_q  <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign type_o  = sreg_q[NWORDS*W-1 -: W];
  assign addr_o  = sreg_q[ADDR_W+DATA_W-1 -: ADDR_W];
  assign wdata_o = sreg_q[DATA_W-1:0];
endmodule

// File: rtl/rap_addr_decode.sv
module rap_addr_decode
  import rap_pkg::*;
(
  input  logic [7:0]       tag_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             hit_o
);
  logic [3:0] region, sub;
  logic       core, fw;
  logic [APP_SLOTS-1:0] app_sel;

  assign region = tag_i[7:4];
  assign sub    = tag_i[3:0];
  assign core   = (region == 4'h0) || (region == 4'h1);
  assign fw     = (region == 4'h2);

  for (genvar g = 0; g < APP_SLOTS; g++) begin : g_app
    assign app_sel[g] = fw && (sub == 4'(4 + g));
  end

  assign sel_o = {fw && (sub == 4'(5 + APP_SLOTS)),
                  fw && (sub == 4'(4 + APP_SLOTS)),
                  app_sel,
                  fw && (sub == 4'h2),
                  fw && (sub == 4'h1),
                  fw && (sub == 4'h0),
                  core};
  assign hit_o = |sel_o;
endmodule

// File: rtl/rap_bus_seq.sv
module rap_bus_seq #(
  parameter int TIMEOUT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic done_o,
  output logic tout_o,
  output logic busy_o
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(TIMEOUT - 1));
  assign done_o = busy_q && (ack_i || last);
  assign tout_o = busy_q && !ack_i && last;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rap_rsp_builder.sv
module rap_rsp_builder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [W-1:0]      type_i,
  input  logic [W-1:0]      status_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [W-1:0]      data_o,
  output logic              last_o,
  output logic              done_o
);
  localparam int NWORDS = 2 + ADDR_W / W + DATA_W / W;
  localparam int CNT_W  = $clog2(NWORDS);

  logic [NWORDS*W-1:0] sreg_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                active_q;

  assign valid_o = active_q;
  assign data_o  = sreg_q[NWORDS*W-1 -: W];
  assign last_o  = active_q && (cnt_q == CNT_W'(NWORDS - 1));
  assign done_o  = last_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      sreg_q   <= {type_i, status_i, addr_i, data_i};
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q && ready_i) begin
      sreg_q <= sreg_q << W;
      cnt_q  <= cnt_q + 1'b1;
      if (last_o) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/reg_access_proc.sv
module reg_access_proc
  import rap_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          TIMEOUT  = 256,
  parameter logic [15:0] UDP_PORT = 16'd1001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [15:0]       req_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [15:0]       rsp_data_o,
  output logic              rsp_last_o,
  output logic [15:0]       rsp_port_o,
  output logic              bus_stb_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [SEL_W-1:0]  bus_sel_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  rap_state_e state_q, state_d;

  logic              parse_done, hit, is_rd, is_wr, type_ok;
  logic              seq_done, seq_tout, seq_busy, rsp_done, load;
  logic [15:0]       req_type, rsp_sts;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_dat;
  logic [SEL_W-1:0]  sel;

  assign req_ready_o = (state_q == ST_RX);
  assign rsp_port_o  = UDP_PORT;

  rap_req_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(WORD_W)) u_parse (
    .clk_i, .rst_ni, .en_i(req_ready_o), .valid_i(req_valid_i), .data_i(req_data_i),
    .done_o(parse_done), .type_o(req_type), .addr_o(req_addr), .wdata_o(req_wdata));

  rap_addr_decode u_dec (.tag_i(req_addr[ADDR_W-1 -: 8]), .sel_o(sel), .hit_o(hit));

  assign is_rd   = (req_type == TYPE_RD);
  assign is_wr   = (req_type == TYPE_WR);
  assign type_ok = is_rd || is_wr;

  assign bus_stb_o   = (state_q == ST_CHK) && type_ok && hit;
  assign bus_we_o    = is_wr;
  assign bus_addr_o  = req_addr;
  assign bus_wdata_o = req_wdata;
  assign bus_sel_o   = (bus_stb_o || seq_busy) ? sel : '0;

  rap_bus_seq #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk_i, .rst_ni, .start_i(bus_stb_o), .ack_i(bus_ack_i),
    .done_o(seq_done), .tout_o(seq_tout), .busy_o(seq_busy));

  always_comb begin
    load    = 1'b0;
    rsp_sts = STS_OK;
    rsp_dat = req_wdata;
    state_d = state_q;
    unique case (state_q)
      ST_RX:  if (parse_done) state_d = ST_CHK;
      ST_CHK: begin
        if (!type_ok) begin
          load    = 1'b1;
          rsp_sts = STS_BAD_TYPE;
          state_d = ST_TX;
        end else if (!hit) begin
          load    = 1'b1;
          rsp_sts = STS_BAD_ADDR;
          rsp_dat = is_rd ? '0 : req_wdata;
          state_d = ST_TX;
        end else begin
          state_d = ST_BUS;
        end
      end
      ST_BUS: if (seq_done) begin
        load    = 1'b1;
        rsp_sts = seq_tout ? STS_TIMEOUT : STS_OK;
        if (is_rd) rsp_dat = seq_tout ? '0 : bus_rdata_i;
        state_d = ST_TX;
      end
      ST_TX:  if (rsp_done) state_d = ST_RX;
      default: state_d = ST_RX;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RX;
    else         state_q <= state_d;
  end

  rap_rsp_builder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(WORD_W)) u_rsp (
    .clk_i, .rst_ni, .load_i(load), .type_i(req_type), .status_i(rsp_sts),
    .addr_i(req_addr), .data_i(rsp_dat), .ready_i(rsp_ready_i),
    .valid_o(rsp_valid_o), .data_o(rsp_data_o), .last_o(rsp_last_o), .done_o(rsp_done));
endmodule

// File: rtl/reg_access_proc_chk.sv
module reg_access_proc_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [15:0]       rsp_data_o,
  input logic              rsp_last_o,
  input logic              bus_stb_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic [SEL_W-1:0]  bus_sel_o
);
  p_stb_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_o |=> !bus_stb_o);

  p_sel_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_o |-> $countones(bus_sel_o) == 1);

  p_sel_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bus_sel_o) <= 1);

  p_bus_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bus_sel_o) |=> $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o));

  p_rsp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o));

  p_one_at_a_time_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o && !bus_stb_o);
endmodule

bind reg_access_proc reg_access_proc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(rap_pkg::SEL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_data_o(rsp_data_o),
  .rsp_last_o(rsp_last_o), .bus_stb_o(bus_stb_o), .bus_we_o(bus_we_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_sel_o(bus_sel_o)
);

// File: tb/tb_reg_access_proc.sv
`timescale 1ns/1ps
module tb_reg_access_proc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_data_i = '0;
  logic        rsp_ready_i = 1'b0;
  logic        bus_ack_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_last_o, bus_stb_o, bus_we_o;
  logic [15:0] rsp_data_o, rsp_port_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [13:0] bus_sel_o;

  reg_access_proc dut (.*);

  always #4 clk_i = ~clk_i;

  int n_checks = 0, n_fail = 0;
  int lat = 1, wait_cnt = 0, stb_cnt = 0, hold_err = 0;
  bit pending = 0;
  logic [31:0] seen_addr = '0, seen_wdata = '0;
  logic [13:0] seen_sel = '0;
  logic        seen_we = 1'b0;
  logic [15:0] got [6];
  logic        got_last [6];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // bus responder: ack after lat cycles past the strobe cycle (0 = never)
  always @(negedge clk_i) begin
    bus_ack_i = 1'b0;
    if (!rst_ni) pending = 0;
    else if (bus_stb_o) begin
      stb_cnt++;
      pending    = 1;
      wait_cnt   = 0;
      seen_addr  = bus_addr_o;
      seen_sel   = bus_sel_o;
      seen_we    = bus_we_o;
      seen_wdata = bus_wdata_o;
    end else if (pending) begin
      wait_cnt++;
      if (wait_cnt <= 256 && (bus_addr_o != seen_addr || bus_sel_o != seen_sel ||
          bus_we_o != seen_we || bus_wdata_o != seen_wdata)) hold_err++;
      if (lat != 0 && wait_cnt == lat) begin
        bus_ack_i   = 1'b1;
        bus_rdata_i = seen_addr ^ 32'h5A5A_C3C3;
        pending     = 0;
      end
    end
  end

  function automatic logic [13:0] exp_sel(input logic [31:0] a);
    logic [3:0] t, s;
    t = a[31:28];
    s = a[27:24];
    if (t < 4'h2) return 14'd1;
    if (t != 4'h2) return 14'd0;
    if (s <= 4'h2) return 14'd1 << (s + 1);
    if (s >= 4'h4 && s <= 4'hD) return 14'd1 << s;
    return 14'd0;
  endfunction

  task automatic send_req(input logic [15:0] typ, input logic [31:0] addr, input logic [31:0] data);
    logic [15:0] w [5];
    w[0] = typ; w[1] = addr[31:16]; w[2] = addr[15:0]; w[3] = data[31:16]; w[4] = data[15:0];
    for (int i = 0; i < 5; i++) begin
      req_valid_i = 1'b1;
      req_data_i  = w[i];
      while (!req_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
  endtask

  task automatic get_rsp(input bit stall);
    int k = 0, cyc = 0;
    bit held = 0, r10_seen = 0;
    logic [15:0] held_w = '0;
    while (k < 6) begin
      if (held) begin
        chk(rsp_valid_o && rsp_data_o == held_w, "R9", "hold", rsp_data_o, held_w);
        held = 0;
      end
      rsp_ready_i = stall ? (cyc % 3 == 2) : 1'b1;
      if (rsp_valid_o && !r10_seen) begin
        chk(!req_ready_o, "R10", "ready during rsp", req_ready_o, 0);
        r10_seen = 1;
      end
      if (rsp_valid_o && rsp_ready_i) begin
        got[k] = rsp_data_o;
        got_last[k] = rsp_last_o;
        k++;
      end else if (rsp_valid_o) begin
        held = 1;
        held_w = rsp_data_o;
      end
      cyc++;
      @(negedge clk_i);
    end
    rsp_ready_i = 1'b0;
  endtask

  task automatic txn(input logic [15:0] typ, input logic [31:0] addr,
                     input logic [31:0] data, input int l, input bit stall);
    bit rd, wr;
    logic [13:0] es;
    logic [15:0] est;
    logic [31:0] ed;
    int s0, h0, estb;
    string st_tag;
    lat = l;
    rd = (typ == 16'h2000);
    wr = (typ == 16'h2001);
    es = exp_sel(addr);
    if (!(rd || wr))                  begin est = 16'h1; st_tag = "R4"; end
    else if (es == 0)                 begin est = 16'h2; st_tag = "R6"; end
    else if (l == 0 || l > 256)       begin est = 16'h3; st_tag = "R8"; end
    else                              begin est = 16'h0; st_tag = "R8"; end
    if (rd) ed = (est == 16'h0) ? (addr ^ 32'h5A5A_C3C3) : 32'h0;
    else    ed = data;
    estb = (est == 16'h0 || est == 16'h3) ? 1 : 0;
    s0 = stb_cnt;
    h0 = hold_err;
    send_req(typ, addr, data);
    get_rsp(stall);
    chk(got[0] == typ, "R9", "type echo", got[0], typ);
    chk(got[1] == est, st_tag, "status", got[1], est);
    chk({got[2], got[3]} == addr, "R9", "addr echo", {got[2], got[3]}, addr);
    chk({got[4], got[5]} == ed, rd ? "R2" : "R3", "data", {got[4], got[5]}, ed);
    for (int i = 0; i < 6; i++)
      chk(got_last[i] == (i == 5), "R9", "last flag", got_last[i], i == 5);
    chk(stb_cnt - s0 == estb, "R7", "strobe count", stb_cnt - s0, estb);
    chk(hold_err == h0, "R7", "bus hold", hold_err - h0, 0);
    if (estb == 1) begin
      chk(seen_sel == es, "R5", "select", seen_sel, es);
      chk(seen_we == wr, "R3", "write flag", seen_we, wr);
      if (wr) chk(seen_wdata == data, "R3", "wdata", seen_wdata, data);
      chk(seen_addr == addr, "R1", "bus addr", seen_addr, addr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!rsp_valid_o && !bus_stb_o && bus_sel_o == 0, "R10", "reset idle", rsp_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1", "reset ready", req_ready_o, 1);
    chk(rsp_port_o == 16'd1001, "R11", "udp port", rsp_port_o, 1001);

    // decode sweep over all region/sub-field pairs, reads then writes
    for (int a = 0; a < 256; a++)
      txn(16'h2000, {a[7:0], 24'h00_1230 + 24'(a)}, 32'hDEAD_0000 + a, 1 + (a % 3), a[0]);
    for (int a = 0; a < 256; a += 5)
      txn(16'h2001, {a[7:0], 24'h0A_0000 + 24'(a)}, 32'h1357_0000 ^ (a * 32'h0101), 2, a[1]);

    // foreign type codes, including with an unmapped address (R4 precedence)
    txn(16'h1FFF, 32'h2100_0004, 32'hCAFE_0001, 1, 0);
    txn(16'h2002, 32'h0000_0010, 32'hCAFE_0002, 1, 1);
    txn(16'h0000, 32'hF000_0000, 32'hCAFE_0003, 1, 0);
    txn(16'hA001, 32'h23FF_FFFF, 32'hCAFE_0004, 1, 0);

    // timeout boundary R8
    txn(16'h2000, 32'h2400_0100, 32'h0, 256, 0);
    txn(16'h2001, 32'h2D00_0200, 32'h7777_8888, 256, 1);
    txn(16'h2000, 32'h2C00_0300, 32'h0, 257, 0);
    txn(16'h2001, 32'h1000_0400, 32'h1111_2222, 257, 0);
    txn(16'h2000, 32'h0000_0500, 32'h0, 0, 1);
    // recovery after a late ack that must be ignored
    txn(16'h2000, 32'h2200_0600, 32'h0, 1, 0);
    chk(rsp_port_o == 16'd1001, "R11", "udp port end", rsp_port_o, 1001);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL all watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule